// File: doc/BRIEF.md
# Transmit Holding Register Empty Interrupt Generator

This block decides when a UART transmitter signals that its holding register has drained. It sits beside a transmit FIFO and watches four things: the FIFO's empty status, its fill level, processor writes to the holding register, and reads of the interrupt identification register.

When the FIFO goes empty, the block raises the interrupt either at once or after a hold-off. The hold-off lasts one character time minus the stop bit. It is counted in bit-time ticks from the configured data length and parity. Software that writes a character into the holding register one at a time can therefore keep the transmitter busy without servicing an interrupt.

If the FIFO held two or more characters at one time since the previous empty event, software has been filling it in bursts. In that case waiting gains nothing, and the interrupt is raised immediately.

Top module: `thre_irq_gen`

## Requirements
- R1: `rst_n` is an active-low synchronous reset. While `rst_n` is low at a clock edge, the block does three things:
  - it drives `thre_irq` low;
  - it clears the burst flag;
  - it stops any countdown.

  A countdown begun before reset never raises `thre_irq` afterwards.
- R2: An empty event is a cycle in which `fifo_empty` is 1 and was 0 in the previous cycle. `fifo_empty` is taken as 1 at reset. If the burst flag is set at an empty event, `thre_irq` is 1 from the next cycle.
- R3: A cycle with `thr_wr` = 1 makes `thre_irq` 0 in the next cycle and abandons any running countdown. A write takes priority over any set condition in the same cycle.
- R4: If the burst flag is clear at an empty event, a countdown starts. Its length N is 1 + D + `parity_en` bit ticks, where D = 5 + `word_len` (`word_len` 0 = 5 bits, 1 = 6, 2 = 7, 3 = 8 data bits). `thre_irq` rises at the clock edge that samples the N-th `bit_tick`. Until then it stays 0.
- R5: A cycle with `iir_rd` = 1 and `iir_id` = 3'b001 clears `thre_irq` in the next cycle. An `iir_rd` with any other `iir_id` value leaves `thre_irq` unchanged.
- R6: The burst flag is set in any cycle with `fifo_level` >= 2. It is cleared at every empty event. So a later single-character drain is held off again.
- R7: `thre_irq` is only ever set while `fifo_empty` is 1. A countdown is abandoned if `fifo_empty` falls before it expires.
- R8: A `bit_tick` in the empty-event cycle itself is not counted toward N.
- R9: Once set, `thre_irq` stays 1 until a write (R3) or a qualifying identification read (R5).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fifo_empty | input | 1 | Transmit FIFO holds no characters |
| fifo_level | input | LEVEL_W | Number of characters now in the transmit FIFO |
| thr_wr | input | 1 | One-cycle strobe: processor write to the holding register |
| iir_rd | input | 1 | One-cycle strobe: read of the interrupt identification register |
| iir_id | input | 3 | Highest-priority pending interrupt code presented on that read |
| word_len | input | WLEN_W | Data length code, data bits = 5 + code |
| parity_en | input | 1 | Parity bit present in each character |
| bit_tick | input | 1 | One-cycle pulse per transmitted bit time |
| thre_irq | output | 1 | Transmit-empty interrupt flag |

## Verification
The properties assume the following about the inputs:
- `thr_wr`, `iir_rd` and `bit_tick` are single-cycle strobes;
- `word_len` and `parity_en` stay fixed while a countdown runs;
- `fifo_level` reads 0 whenever `fifo_empty` is 1.

The stimulus drives strobes for exactly one cycle. It changes the character format only between drains, and it always sets the level to 0 in the same cycle that the FIFO is marked empty.

Writes and identification reads are issued while the FIFO is still flagged empty. This shows the clearing rules separately from the FIFO refill that would normally follow.

// File: rtl/thre_pkg.sv
// Package: shared constants and helpers for the transmit-empty interrupt block.
// Assumes a data-length code that counts upward from the minimum character size.
package thre_pkg;

    // Smallest supported number of data bits in a character.
    localparam int unsigned MIN_DATA_BITS = 5;

    // Identification code reported when this source is the highest priority.
    localparam logic [2:0] IID_TX_EMPTY = 3'b001;

    // Counter width able to hold the longest held-off span:
    // start + largest data length + parity.
    function automatic int unsigned span_width(input int unsigned wlen_w);
        int unsigned max_span;
        max_span = 1 + MIN_DATA_BITS + ((1 << wlen_w) - 1) + 1;
        return $clog2(max_span + 1);
    endfunction

endpackage

// File: rtl/thre_fill_tracker.sv
// Module: thre_fill_tracker
// Keeps a sticky flag recording that the transmit FIFO held at least THRESH
// characters at one time since the most recent empty event.
// Assumes fifo_level is a plain binary count and empty_event is one cycle wide.
module thre_fill_tracker #(
    parameter int unsigned LEVEL_W = 5,
    parameter int unsigned THRESH  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LEVEL_W-1:0] fifo_level,
    input  logic               empty_event,
    output logic               burst_seen
);

    localparam logic [LEVEL_W-1:0] THRESH_V = LEVEL_W'(THRESH);

    logic burst_q;

    // Flag update: cleared on each drain, set whenever the level reaches the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_q <= 1'b0;
        end else if (empty_event) begin
            burst_q <= 1'b0;
        end else if (fifo_level >= THRESH_V) begin
            burst_q <= 1'b1;
        end
    end

    assign burst_seen = burst_q;

endmodule

// File: rtl/thre_char_timer.sv
// Module: thre_char_timer
// Down-counter for the hold-off span, measured in bit-time ticks.
// Loads span on start, abandons on cancel, and pulses done combinationally in the
// cycle that carries the last required tick.
// Assumes span is at least 1 and stays valid in the start cycle.
module thre_char_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] span,
    input  logic             cancel,
    input  logic             bit_tick,
    output logic             done,
    output logic             busy
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] remain_q;
    logic             run_q;

    // Expiry: the tick that brings the remaining count from one to zero.
    always_comb begin
        done = run_q && bit_tick && (remain_q == ONE) && !start && !cancel;
    end

    // Count state: load, abandon, or step down on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            run_q    <= 1'b0;
        end else if (start) begin
            remain_q <= span;
            run_q    <= 1'b1;
        end else if (cancel) begin
            remain_q <= '0;
            run_q    <= 1'b0;
        end else if (run_q && bit_tick) begin
            remain_q <= remain_q - ONE;
            if (remain_q == ONE) begin
                run_q <= 1'b0;
            end
        end
    end

    assign busy = run_q;

endmodule

// File: rtl/thre_irq_gen.sv
// Module: thre_irq_gen (top)
// Generates the transmit-holding-register-empty interrupt. On each empty event
// it either raises the flag at once (after a burst fill) or after one character
// time minus the stop bit. Writes and qualifying identification reads clear it.
// Assumes single-cycle strobes and a character format held steady while counting.
module thre_irq_gen
    import thre_pkg::*;
#(
    parameter int unsigned LEVEL_W      = 5,
    parameter int unsigned WLEN_W       = 2,
    parameter int unsigned BURST_THRESH = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fifo_empty,
    input  logic [LEVEL_W-1:0] fifo_level,
    input  logic               thr_wr,
    input  logic               iir_rd,
    input  logic [2:0]         iir_id,
    input  logic [WLEN_W-1:0]  word_len,
    input  logic               parity_en,
    input  logic               bit_tick,
    output logic               thre_irq
);

    localparam int unsigned CNT_W = span_width(WLEN_W);

    logic             empty_q;
    logic             empty_event;
    logic             burst_seen;
    logic [CNT_W-1:0] span;
    logic             tmr_start;
    logic             tmr_cancel;
    logic             tmr_done;
    logic             tmr_busy;
    logic             set_now;
    logic             clr_read;
    logic             irq_q;

    // Remember last cycle's empty status to find the drain edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty_q <= 1'b1;
        end else begin
            empty_q <= fifo_empty;
        end
    end

    // Drain edge detection.
    always_comb begin
        empty_event = fifo_empty && !empty_q;
    end

    // Hold-off span: start bit + data bits + optional parity, stop bit excluded.
    always_comb begin
        span = CNT_W'(1) + CNT_W'(MIN_DATA_BITS) + CNT_W'(word_len) + CNT_W'(parity_en);
    end

    // Timer control: start on a non-burst drain, abandon on refill or write.
    always_comb begin
        tmr_start  = empty_event && !burst_seen && !thr_wr;
        tmr_cancel = thr_wr || !fifo_empty;
    end

    // Set and clear conditions for the interrupt flag.
    always_comb begin
        set_now  = (empty_event && burst_seen) || (tmr_done && fifo_empty);
        clr_read = iir_rd && (iir_id == IID_TX_EMPTY);
    end

    // Interrupt flag: write clears first, then set, then identification read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (thr_wr) begin
            irq_q <= 1'b0;
        end else if (set_now) begin
            irq_q <= 1'b1;
        end else if (clr_read) begin
            irq_q <= 1'b0;
        end
    end

    thre_fill_tracker #(
        .LEVEL_W (LEVEL_W),
        .THRESH  (BURST_THRESH)
    ) u_fill (
        .clk         (clk),
        .rst_n       (rst_n),
        .fifo_level  (fifo_level),
        .empty_event (empty_event),
        .burst_seen  (burst_seen)
    );

    thre_char_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (tmr_start),
        .span     (span),
        .cancel   (tmr_cancel),
        .bit_tick (bit_tick),
        .done     (tmr_done),
        .busy     (tmr_busy)
    );

    assign thre_irq = irq_q;

endmodule

// File: rtl/thre_irq_gen_checker.sv
// Module: thre_irq_gen_checker
// Temporal properties of the transmit-empty interrupt, observed at the ports.
// Assumes the same reset convention as the design (empty status taken as 1).
module thre_irq_gen_checker #(
    parameter int unsigned LEVEL_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               fifo_empty,
    input logic [LEVEL_W-1:0] fifo_level,
    input logic               thr_wr,
    input logic               iir_rd,
    input logic [2:0]         iir_id,
    input logic               bit_tick,
    input logic               thre_irq
);

    logic emp_seen_q;

    // Private copy of the previous empty status for the rise check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            emp_seen_q <= 1'b1;
        end else begin
            emp_seen_q <= fifo_empty;
        end
    end

    // R1: the flag is low in the cycle after a reset edge.
    assert_reset_low_R1: assert property (@(posedge clk) !rst_n |=> !thre_irq);

    // R3: a write always leaves the flag low.
    assert_write_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> !thre_irq);

    // R5: a read reporting another source does not clear.
    assert_foreign_read_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (thre_irq && iir_rd && iir_id != 3'b001 && !thr_wr) |=> thre_irq);

    // R7: no rise while the FIFO holds data.
    assert_rise_only_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!thre_irq && !fifo_empty) |=> !thre_irq);

    // R4: a rise follows either a drain edge or a bit tick.
    assert_rise_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(thre_irq) |-> ($past(bit_tick) || $past(fifo_empty && !emp_seen_q)));

    // R9: the flag holds until a clearing access.
    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (thre_irq && !thr_wr && !(iir_rd && iir_id == 3'b001)) |=> thre_irq);

    // R6: occupancy input consistency; an empty FIFO reports level zero.
    assert_level_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty |-> (fifo_level == '0));

endmodule

bind thre_irq_gen thre_irq_gen_checker #(.LEVEL_W(LEVEL_W)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_empty (fifo_empty),
    .fifo_level (fifo_level),
    .thr_wr     (thr_wr),
    .iir_rd     (iir_rd),
    .iir_id     (iir_id),
    .bit_tick   (bit_tick),
    .thre_irq   (thre_irq)
);

// File: tb/test_thre_irq_gen.sv
// Bench: sweeps character formats, tick spacings and fill patterns; expected
// interrupt timing computed from the span formula of the requirements.
module test_thre_irq_gen;

    localparam int unsigned LEVEL_W = 5;
    localparam int unsigned WLEN_W  = 2;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               fifo_empty;
    logic [LEVEL_W-1:0] fifo_level;
    logic               thr_wr;
    logic               iir_rd;
    logic [2:0]         iir_id;
    logic [WLEN_W-1:0]  word_len;
    logic               parity_en;
    logic               bit_tick;
    logic               thre_irq;

    int vectors     = 0;
    int miscompares = 0;
    bit finished    = 1'b0;

    always #5 clk = ~clk;

    thre_irq_gen #(.LEVEL_W(LEVEL_W), .WLEN_W(WLEN_W)) i_thre_irq_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_empty (fifo_empty),
        .fifo_level (fifo_level),
        .thr_wr     (thr_wr),
        .iir_rd     (iir_rd),
        .iir_id     (iir_id),
        .word_len   (word_len),
        .parity_en  (parity_en),
        .bit_tick   (bit_tick),
        .thre_irq   (thre_irq)
    );

    task automatic chk(input logic exp, input string req);
        vectors++;
        if (thre_irq !== exp) begin
            miscompares++;
            $display("FAIL %s: thre_irq=%0b expected %0b at %0t", req, thre_irq, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic fill(input int lvl);
        fifo_empty = 1'b0;
        fifo_level = LEVEL_W'(lvl);
        step();
    endtask

    task automatic drain(input bit tick_now);
        fifo_empty = 1'b1;
        fifo_level = '0;
        bit_tick   = tick_now;
        step();
        bit_tick = 1'b0;
    endtask

    task automatic tick();
        bit_tick = 1'b1;
        step();
        bit_tick = 1'b0;
    endtask

    task automatic write_thr();
        thr_wr = 1'b1;
        step();
        thr_wr = 1'b0;
    endtask

    task automatic read_iir(input logic [2:0] code);
        iir_rd = 1'b1;
        iir_id = code;
        step();
        iir_rd = 1'b0;
        iir_id = 3'b000;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: thre_irq=%0b expected run to finish", thre_irq);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        int span;
        rst_n      = 1'b0;
        fifo_empty = 1'b1;
        fifo_level = '0;
        thr_wr     = 1'b0;
        iir_rd     = 1'b0;
        iir_id     = 3'b000;
        word_len   = '0;
        parity_en  = 1'b0;
        bit_tick   = 1'b0;
        @(negedge clk);
        do_reset();
        chk(1'b0, "R1 reset state");

        // R4/R8/R5/R3: held-off drain across all formats and tick spacings.
        for (int wl = 0; wl < 4; wl++) begin
            for (int par = 0; par < 2; par++) begin
                for (int gap = 0; gap < 3; gap++) begin
                    word_len  = WLEN_W'(wl);
                    parity_en = par[0];
                    span = 1 + 5 + wl + par;
                    fill(1);
                    drain(gap == 1);          // R8: tick in event cycle ignored
                    chk(1'b0, "R4 no immediate set");
                    for (int k = 1; k <= span; k++) begin
                        for (int g = 0; g < gap; g++) begin
                            step();
                            chk(1'b0, "R4 idle between ticks");
                        end
                        tick();
                        chk(k == span, "R4 countdown");
                    end
                    step();
                    chk(1'b1, "R9 holds");
                    read_iir(3'b010);
                    chk(1'b1, "R5 foreign code ignored");
                    if (par == 0) begin
                        read_iir(3'b001);
                        chk(1'b0, "R5 read clears");
                    end else begin
                        write_thr();
                        chk(1'b0, "R3 write clears");
                    end
                end
            end
        end

        // R2/R6: burst fill gives an immediate flag, then the flag is consumed.
        word_len  = 2'd3;
        parity_en = 1'b1;
        for (int lvl = 2; lvl < 32; lvl += 7) begin
            fill(lvl);
            fill(1);
            drain(1'b0);
            chk(1'b1, "R2 immediate after burst");
            write_thr();
            chk(1'b0, "R3 write clears");
            fill(1);
            drain(1'b0);
            chk(1'b0, "R6 burst flag cleared by drain");
            for (int k = 1; k <= 10; k++) begin
                tick();
                chk(k == 10, "R6 held off again");
            end
            write_thr();
        end

        // R3: write during countdown abandons it.
        fill(1);
        drain(1'b0);
        tick();
        tick();
        write_thr();
        for (int k = 0; k < 14; k++) begin
            tick();
            chk(1'b0, "R3 countdown abandoned by write");
        end

        // R3: write in the drain cycle beats an immediate set.
        fill(3);
        fifo_empty = 1'b1;
        fifo_level = '0;
        thr_wr     = 1'b1;
        step();
        thr_wr = 1'b0;
        chk(1'b0, "R3 write beats set");
        for (int k = 0; k < 12; k++) begin
            tick();
        end
        chk(1'b0, "R3 no countdown after write");

        // R7: refill during countdown abandons it.
        fill(1);
        drain(1'b0);
        tick();
        fill(1);
        for (int k = 0; k < 14; k++) begin
            tick();
            chk(1'b0, "R7 refill abandons");
        end

        // R1: reset in mid-countdown leaves the flag low.
        drain(1'b0);
        tick();
        do_reset();
        for (int k = 0; k < 14; k++) begin
            tick();
            chk(1'b0, "R1 reset abandons countdown");
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule